// File: doc/BRIEF.md
# Dual-Port Debug Mailbox

This block carries single words between an external debug host and on-chip boot firmware. A transmit mailbox moves command words from the host to the device. A receive mailbox moves response words from the device back to the host. Each mailbox holds one data word, a FULL/EMPTY status and seven software flag bits.

The block has two register ports, one for the host and one for the device. Each port has its own word address, write strobe, read strobe, write data and read data, and both ports share one clock. Read data is combinational from the current register contents, so a read sees the value held before the clock edge that ends its cycle. Status changes take effect at that edge.

Each mailbox is a two-state machine with the states ST_EMPTY and ST_FULL. It has four named transitions:
- FILL: ST_EMPTY to ST_FULL, on a push.
- REFILL: ST_FULL to ST_FULL, on a push. The data is overwritten.
- DRAIN: ST_FULL to ST_EMPTY, on a consuming read with no push in the same cycle.
- STALE: ST_EMPTY to ST_EMPTY, on a consuming read that finds the mailbox empty.

A push always wins over a consuming read in the same cycle. Two pulse outputs report a FILL of the transmit mailbox and a DRAIN of the receive mailbox.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset all data words, status bits and flag bits are zero, both event outputs are low, and every readable address returns zero.
- R2: A host write to word address 0 (transmit data) stores the word and makes the transmit status FULL. A write while FULL replaces the word and the status stays FULL.
- R3: A device read of address 0 makes the transmit status EMPTY from the next cycle on. A host read of address 0 leaves the status unchanged. A device read while EMPTY returns the stored word and the status stays EMPTY.
- R4: If a host write and a device read of address 0 occur in the same cycle, the device reads the previous word, the new word is stored, and the status is FULL afterwards.
- R5: A device write to address 2 (receive data) stores the word and makes the receive status FULL. A read of address 2 from either port makes it EMPTY. A read while EMPTY returns the stored word and the status stays EMPTY.
- R6: If a device write and a host read of address 2 occur in the same cycle, the host reads the old word, the new word is stored, and the receive status is FULL afterwards.
- R7: Address 1 (transmit control) and address 3 (receive control) read as status in bit 0, flags in bits 7:1, and zero in bits 31:8. Only a host write to address 1 loads the transmit flags, from write data bits 7:1. Only a device write to address 3 loads the receive flags, from write data bits 7:1.
- R8: The following writes change nothing that either port can read: device writes to addresses 0 and 1, host writes to addresses 2 and 3, and writes from either port to addresses 4 to 7.
- R9: Address 4 returns the transmit word and address 5 returns the receive word, to either port, and reading them never changes a status. Addresses 6 and 7 read as zero.
- R10: tx_event is high for exactly the one cycle in which the transmit status first reads FULL after being EMPTY. rx_event is high for exactly the one cycle in which the receive status first reads EMPTY after being FULL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_addr | input | 3 | Host word address |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe; only a strobed read of address 2 consumes a word |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for h_addr |
| d_addr | input | 3 | Device word address |
| d_wr | input | 1 | Device write strobe |
| d_rd | input | 1 | Device read strobe; only a strobed read of address 0 or 2 consumes a word |
| d_wdata | input | 32 | Device write data |
| d_rdata | output | 32 | Device read data for d_addr |
| tx_event | output | 1 | One-cycle pulse on a transmit FILL |
| rx_event | output | 1 | One-cycle pulse on a receive DRAIN |

## Verification
A mailbox stuck in the wrong state shows up in bit 0 of its control word on the very next read of that address, from either port. It also shows up as a missing or extra event pulse one cycle after the edge that should have moved it. Corrupted data or flags show up on the same cycle at the data, peek or control addresses. A wrong collision rule shows up in two places: in the collision cycle itself, as the wrong word at the reading port, and one cycle later, as a wrong status. The reference model is compared against both read buses and both events on every cycle, so a fault is reported no later than the first cycle in which the affected register is addressed.

// File: rtl/dbg_mailbox_pkg.sv
package dbg_mailbox_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_TXDATA = 3'd0,
        A_TXCTRL = 3'd1,
        A_RXDATA = 3'd2,
        A_RXCTRL = 3'd3,
        A_TXPEEK = 3'd4,
        A_RXPEEK = 3'd5,
        A_RSVD6  = 3'd6,
        A_RSVD7  = 3'd7
    } reg_idx_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } mbx_state_e;

endpackage

// File: rtl/mbx_channel.sv
module mbx_channel
    import dbg_mailbox_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o,
    output logic              fill_ev_o,
    output logic              drain_ev_o
);

    mbx_state_e        state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic              fill_q, drain_q;

    // Next state: a push wins over a consuming read in the same cycle.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: state_d = push_i ? ST_FULL : ST_EMPTY;        // FILL or STALE
            ST_FULL:  state_d = (pop_i && !push_i) ? ST_EMPTY : ST_FULL; // DRAIN or REFILL
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            fill_q  <= 1'b0;
            drain_q <= 1'b0;
        end else begin
            if (push_i) data_q <= wdata_i;
            fill_q  <= (state_q == ST_EMPTY) && (state_d == ST_FULL);
            drain_q <= (state_q == ST_FULL)  && (state_d == ST_EMPTY);
        end
    end

    assign data_o     = data_q;
    assign full_o     = (state_q == ST_FULL);
    assign fill_ev_o  = fill_q;
    assign drain_ev_o = drain_q;

    a_r2_push_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> full_o);
    a_r2_push_stores: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (data_o == $past(wdata_i)));
    a_r3_pop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> !full_o);
    a_r4_collide_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> full_o);
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i) |=> ($stable(full_o) && $stable(data_o)));
    a_r10_fill_single: assert property (@(posedge clk) disable iff (!rst_n)
        fill_ev_o |=> !fill_ev_o);
    a_r10_fill_full: assert property (@(posedge clk) disable iff (!rst_n)
        fill_ev_o |-> full_o);
    a_r10_drain_empty: assert property (@(posedge clk) disable iff (!rst_n)
        drain_ev_o |-> !full_o);

endmodule

// File: rtl/mbx_flag_reg.sv
module mbx_flag_reg #(
    parameter int DATA_W = 32,
    parameter int FLAG_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [FLAG_W-1:0] flags_o
);

    logic [FLAG_W-1:0] flags_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    flags_q <= '0;
        else if (we_i) flags_q <= wdata_i[FLAG_W:1];
    end

    assign flags_o = flags_q;

    a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(flags_o));

endmodule

// File: rtl/mbx_read_mux.sv
module mbx_read_mux
    import dbg_mailbox_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic [DATA_W-1:0] tx_ctrl_i,
    input  logic [DATA_W-1:0] rx_data_i,
    input  logic [DATA_W-1:0] rx_ctrl_i,
    output logic [DATA_W-1:0] rdata_o
);

    always_comb begin
        rdata_o = '0;
        unique case (reg_idx_e'(addr_i))
            A_TXDATA, A_TXPEEK: rdata_o = tx_data_i;
            A_RXDATA, A_RXPEEK: rdata_o = rx_data_i;
            A_TXCTRL:           rdata_o = tx_ctrl_i;
            A_RXCTRL:           rdata_o = rx_ctrl_i;
            default:            rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
    import dbg_mailbox_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FLAG_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        h_addr,
    input  logic              h_wr,
    input  logic              h_rd,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    input  logic [2:0]        d_addr,
    input  logic              d_wr,
    input  logic              d_rd,
    input  logic [DATA_W-1:0] d_wdata,
    output logic [DATA_W-1:0] d_rdata,
    output logic              tx_event,
    output logic              rx_event
);

    localparam int NUM_PORTS = 2;
    localparam int PAD_W     = DATA_W - FLAG_W - 1;

    logic              tx_push, tx_pop, rx_push, rx_pop;
    logic              tx_flag_we, rx_flag_we;
    logic [DATA_W-1:0] tx_data, rx_data, tx_ctrl, rx_ctrl;
    logic              tx_full, rx_full;
    logic              tx_fill_ev, tx_drain_ev, rx_fill_ev, rx_drain_ev;
    logic [FLAG_W-1:0] tx_flags, rx_flags;

    // Access rights: the host fills the transmit side, the device fills the receive side.
    assign tx_push    = h_wr && (h_addr == A_TXDATA);
    assign tx_pop     = d_rd && (d_addr == A_TXDATA);
    assign rx_push    = d_wr && (d_addr == A_RXDATA);
    assign rx_pop     = (h_rd && (h_addr == A_RXDATA)) || (d_rd && (d_addr == A_RXDATA));
    assign tx_flag_we = h_wr && (h_addr == A_TXCTRL);
    assign rx_flag_we = d_wr && (d_addr == A_RXCTRL);

    mbx_channel #(.DATA_W(DATA_W)) i_tx_chan (
        .clk(clk), .rst_n(rst_n), .push_i(tx_push), .pop_i(tx_pop), .wdata_i(h_wdata),
        .data_o(tx_data), .full_o(tx_full), .fill_ev_o(tx_fill_ev), .drain_ev_o(tx_drain_ev)
    );

    mbx_channel #(.DATA_W(DATA_W)) i_rx_chan (
        .clk(clk), .rst_n(rst_n), .push_i(rx_push), .pop_i(rx_pop), .wdata_i(d_wdata),
        .data_o(rx_data), .full_o(rx_full), .fill_ev_o(rx_fill_ev), .drain_ev_o(rx_drain_ev)
    );

    mbx_flag_reg #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) i_tx_flags (
        .clk(clk), .rst_n(rst_n), .we_i(tx_flag_we), .wdata_i(h_wdata), .flags_o(tx_flags)
    );

    mbx_flag_reg #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) i_rx_flags (
        .clk(clk), .rst_n(rst_n), .we_i(rx_flag_we), .wdata_i(d_wdata), .flags_o(rx_flags)
    );

    assign tx_ctrl = {{PAD_W{1'b0}}, tx_flags, tx_full};
    assign rx_ctrl = {{PAD_W{1'b0}}, rx_flags, rx_full};

    logic [ADDR_W-1:0] port_addr  [NUM_PORTS];
    logic [DATA_W-1:0] port_rdata [NUM_PORTS];

    assign port_addr[0] = h_addr;
    assign port_addr[1] = d_addr;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        mbx_read_mux #(.DATA_W(DATA_W)) i_mux (
            .addr_i(port_addr[p]), .tx_data_i(tx_data), .tx_ctrl_i(tx_ctrl),
            .rx_data_i(rx_data), .rx_ctrl_i(rx_ctrl), .rdata_o(port_rdata[p])
        );
    end

    assign h_rdata  = port_rdata[0];
    assign d_rdata  = port_rdata[1];
    assign tx_event = tx_fill_ev;
    assign rx_event = rx_drain_ev;

    a_r7_ctrl_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        ((h_addr == A_TXCTRL) || (h_addr == A_RXCTRL)) |-> (h_rdata[DATA_W-1:FLAG_W+1] == '0));
    a_r8_dev_tx_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (d_wr && !h_wr && (d_addr == A_TXDATA)) |=> $stable(tx_data));
    a_r8_host_rx_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && !d_wr && (h_addr == A_RXDATA)) |=> $stable(rx_data));
    a_r9_peek_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd && (h_addr == A_RXPEEK) && !rx_push && !(d_rd && (d_addr == A_RXDATA)))
        |=> $stable(rx_full));
    a_r10_rx_event_after_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && !rx_push && rx_full) |=> rx_event);

endmodule

// File: tb/test_dbg_mailbox.sv
module test_dbg_mailbox;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  h_addr = '0, d_addr = '0;
    logic        h_wr = 0, h_rd = 0, d_wr = 0, d_rd = 0;
    logic [31:0] h_wdata = '0, d_wdata = '0;
    logic [31:0] h_rdata, d_rdata;
    logic        tx_event, rx_event;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_mailbox i_dbg_mailbox (
        .clk(clk), .rst_n(rst_n),
        .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .d_addr(d_addr), .d_wr(d_wr), .d_rd(d_rd), .d_wdata(d_wdata), .d_rdata(d_rdata),
        .tx_event(tx_event), .rx_event(rx_event)
    );

    // Behavioural reference model
    int unsigned m_tx_d = 0, m_rx_d = 0;
    bit          m_tx_full = 0, m_rx_full = 0;
    int unsigned m_tx_flags = 0, m_rx_flags = 0;
    bit          e_txev = 0, e_rxev = 0;

    int  n_checks = 0, n_fails = 0;
    bit  reported = 0;

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0, 3'd4: return m_tx_d;
            3'd2, 3'd5: return m_rx_d;
            3'd1:       return (m_tx_flags << 1) | m_tx_full;
            3'd3:       return (m_rx_flags << 1) | m_rx_full;
            default:    return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        end
    endtask

    task automatic step(input string tag,
                        input logic [2:0] ha, input bit hw, input bit hr, input logic [31:0] hwd,
                        input logic [2:0] da, input bit dw, input bit dr, input logic [31:0] dwd);
        bit tpush, tpop, rpush, rpop;
        @(negedge clk);
        check("R10", "tx_event", {31'b0, tx_event}, {31'b0, e_txev});
        check("R10", "rx_event", {31'b0, rx_event}, {31'b0, e_rxev});
        h_addr = ha; h_wr = hw; h_rd = hr; h_wdata = hwd;
        d_addr = da; d_wr = dw; d_rd = dr; d_wdata = dwd;
        #1;
        check(tag, "h_rdata", h_rdata, exp_read(ha));
        check(tag, "d_rdata", d_rdata, exp_read(da));
        tpush = hw && (ha == 3'd0);
        tpop  = dr && (da == 3'd0);
        rpush = dw && (da == 3'd2);
        rpop  = (hr && (ha == 3'd2)) || (dr && (da == 3'd2));
        if (hw && ha == 3'd1) m_tx_flags = (hwd >> 1) & 32'h7f;
        if (dw && da == 3'd3) m_rx_flags = (dwd >> 1) & 32'h7f;
        e_txev = !m_tx_full && tpush;
        e_rxev = m_rx_full && rpop && !rpush;
        if (tpush) begin m_tx_d = hwd; m_tx_full = 1; end
        else if (tpop) m_tx_full = 0;
        if (rpush) begin m_rx_d = dwd; m_rx_full = 1; end
        else if (rpop) m_rx_full = 0;
    endtask

    task automatic idle(input string tag, input logic [2:0] ha, input logic [2:0] da);
        step(tag, ha, 0, 0, 0, da, 0, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        idle("R1", 3'd1, 3'd3);
        idle("R1", 3'd0, 3'd2);
        idle("R1", 3'd4, 3'd5);
        // R2 host write fills transmit
        step("R2", 3'd0, 1, 0, 32'hA5A5_0001, 3'd1, 0, 0, 0);
        idle("R2", 3'd1, 3'd1);
        step("R2", 3'd0, 1, 0, 32'h1234_5678, 3'd0, 0, 0, 0);   // overwrite while FULL
        // R3 host read no consume, device read consumes
        step("R3", 3'd0, 0, 1, 0, 3'd1, 0, 0, 0);
        idle("R3", 3'd1, 3'd1);
        step("R3", 3'd1, 0, 0, 0, 3'd0, 0, 1, 0);
        idle("R3", 3'd1, 3'd1);
        step("R3", 3'd1, 0, 0, 0, 3'd0, 0, 1, 0);               // stale read on EMPTY
        idle("R3", 3'd1, 3'd0);
        // R4 collision on transmit
        step("R4", 3'd0, 1, 0, 32'hAAAA_0001, 3'd1, 0, 0, 0);
        step("R4", 3'd0, 1, 0, 32'hBBBB_0002, 3'd0, 0, 1, 0);
        idle("R4", 3'd1, 3'd0);
        step("R4", 3'd1, 0, 0, 0, 3'd0, 0, 1, 0);
        // R5 receive fill and drain by host, then by device
        step("R5", 3'd3, 0, 0, 0, 3'd2, 1, 0, 32'hC0DE_0001);
        idle("R5", 3'd3, 3'd3);
        step("R5", 3'd2, 0, 1, 0, 3'd3, 0, 0, 0);
        idle("R5", 3'd3, 3'd3);
        step("R5", 3'd2, 0, 1, 0, 3'd3, 0, 0, 0);               // stale host read
        step("R5", 3'd3, 0, 0, 0, 3'd2, 1, 0, 32'hC0DE_0002);
        step("R5", 3'd3, 0, 0, 0, 3'd2, 0, 1, 0);               // device flush
        idle("R5", 3'd3, 3'd2);
        // R6 receive collision
        step("R6", 3'd3, 0, 0, 0, 3'd2, 1, 0, 32'hDDDD_0001);
        step("R6", 3'd2, 0, 1, 0, 3'd2, 1, 0, 32'hEEEE_0002);
        idle("R6", 3'd3, 3'd2);
        // R7 flag ownership and control layout
        step("R7", 3'd1, 1, 0, 32'hFFFF_FFFF, 3'd1, 0, 0, 0);
        idle("R7", 3'd1, 3'd1);
        step("R7", 3'd3, 0, 0, 0, 3'd3, 1, 0, 32'h0000_00AA);
        idle("R7", 3'd3, 3'd3);
        // R8 writes without rights
        step("R8", 3'd1, 0, 0, 0, 3'd1, 1, 0, 32'h0000_0000);
        step("R8", 3'd0, 0, 0, 0, 3'd0, 1, 0, 32'h5555_5555);
        step("R8", 3'd3, 1, 0, 32'h0000_0000, 3'd3, 0, 0, 0);
        step("R8", 3'd2, 1, 0, 32'h6666_6666, 3'd2, 0, 0, 0);
        step("R8", 3'd4, 1, 0, 32'h7777_7777, 3'd5, 1, 0, 32'h8888_8888);
        step("R8", 3'd6, 1, 0, 32'h9999_9999, 3'd7, 1, 0, 32'h9999_9999);
        idle("R8", 3'd1, 3'd3);
        idle("R8", 3'd0, 3'd2);
        // R9 peeks do not consume
        step("R9", 3'd4, 0, 1, 0, 3'd4, 0, 1, 0);
        step("R9", 3'd5, 0, 1, 0, 3'd5, 0, 1, 0);
        idle("R9", 3'd1, 3'd3);
        idle("R9", 3'd6, 3'd7);
        // Mixed traffic against the model
        for (int i = 0; i < 600; i++) begin
            step("R2/R5 mixed", 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), $urandom,
                 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), $urandom);
        end
        idle("R10", 3'd1, 3'd3);
        idle("R10", 3'd1, 3'd3);
        report();
        $finish;
    end

endmodule